// File: doc/BRIEF.md
# Dual Clocked Monostable Pulse Generator

This block turns a single trigger event into one output pulse of a programmed number of clock cycles. It has two channels that do not interact. Each channel has a rising-edge trigger, a falling-edge trigger and an active-low clear. Each trigger only counts while the other trigger input is at its idle level. A programmable cycle count sets the pulse length, so no timing network is needed.

Each channel can run in one of two modes. In the extending mode, every accepted trigger restarts the full period. In the fixed mode, the first trigger sets the pulse, and further triggers are ignored until the output falls.

Both trigger inputs are asynchronous to the clock and are synchronised before edge detection. The output therefore starts a fixed number of cycles after the trigger, whatever the period is. Because of this, a trigger must hold each level for at least one clock cycle to be seen.

Top module: `oneshot_pair`

## Requirements
- R1: After the power-on reset `rst_n` is released, every channel shows `pulse` = 0 and `pulse_n` = 1, and stays so until a trigger is accepted.
- R2: While `clear_n[c]` is 0, `pulse[c]` is 0 and `pulse_n[c]` is 1, whatever the triggers do.
- R3: A 0-to-1 transition on `lead_trig[c]` while `trail_trig[c]` is 1 starts a pulse. The pulse is high from the third falling clock edge after the input change, for exactly P cycles, where P is `period[c*PERIOD_W +: PERIOD_W]`.
- R4: A 1-to-0 transition on `trail_trig[c]` while `lead_trig[c]` is 0 starts a pulse with the same latency and width as in R3.
- R5: A rising `lead_trig` is ignored while `trail_trig` is 0. A falling `trail_trig` is ignored while `lead_trig` is 1. Static levels with no qualifying transition never raise `pulse`.
- R6: With `retrig_en[c]` = 1, a trigger accepted D cycles after the first one, with 2 <= D <= P, extends the pulse so that its total width is D + P.
- R7: With `retrig_en[c]` = 0, a trigger that arrives while the pulse is high is ignored, and the width stays P.
- R8: When P = 0, no pulse is produced.
- R9: Releasing `clear_n` never starts a pulse. A trigger whose detection falls in a cycle where `clear_n` is 0 is discarded. Asserting `clear_n` ends an active pulse, and the pulse does not resume after the release.
- R10: Each channel's triggers, clear, mode and period affect only that channel's outputs.
- R11: `pulse_n` is always the bitwise complement of `pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| lead_trig | input | NCH | Rising-edge trigger, one bit per channel |
| trail_trig | input | NCH | Falling-edge trigger, one bit per channel |
| clear_n | input | NCH | Per-channel clear, active low, overrides everything |
| retrig_en | input | NCH | 1 = each trigger restarts the period, 0 = triggers ignored while active |
| period | input | NCH*PERIOD_W | Pulse length in cycles, channel c at bits c*PERIOD_W upward |
| pulse | output | NCH | Pulse output, active high |
| pulse_n | output | NCH | Complement of pulse |

## Verification
Single triggers are swept over both edge types, both channels and periods 1 to 6. This sweep separates a wrong width or a wrong fixed latency from a wrong edge polarity. Paired triggers are swept over every spacing from 2 up to the period, in both modes. These runs tell an extending reload from an ignored one and catch off-by-one errors in the reload cycle. Directed patterns cover the following:
- blocked edges and static levels, which exercise the cross gating;
- a clear that lines up with the detection cycle, a clear in mid-pulse, and a clear release;
- a zero period;
- both channels running together with different periods while one of them is cleared.

// File: rtl/oneshot_pair.sv
module oneshot_pair #(
  parameter int NCH      = 2,
  parameter int PERIOD_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCH-1:0]          lead_trig,
  input  logic [NCH-1:0]          trail_trig,
  input  logic [NCH-1:0]          clear_n,
  input  logic [NCH-1:0]          retrig_en,
  input  logic [NCH*PERIOD_W-1:0] period,
  output logic [NCH-1:0]          pulse,
  output logic [NCH-1:0]          pulse_n
);

  localparam int HIST = 3;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [HIST-1:0]     lead_h, trail_h;
    logic [PERIOD_W-1:0] cnt;
    logic [PERIOD_W-1:0] len;
    logic                lead_rise, trail_fall, fire, busy;

    assign len = period[g*PERIOD_W +: PERIOD_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lead_h  <= '0;
        trail_h <= '1;
      end else begin
        lead_h  <= {lead_h[HIST-2:0], lead_trig[g]};
        trail_h <= {trail_h[HIST-2:0], trail_trig[g]};
      end
    end

    // bit 1 is the synchronised level, bit 2 the level one cycle earlier
    assign lead_rise  =  lead_h[1] & ~lead_h[2] &  trail_h[1];
    assign trail_fall = ~trail_h[1] & trail_h[2] & ~lead_h[1];
    assign fire       = (lead_rise | trail_fall) & clear_n[g];
    assign busy       = (cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt <= '0;
      else if (!clear_n[g])
        cnt <= '0;
      else if (fire && (retrig_en[g] || !busy))
        cnt <= len;
      else if (busy)
        cnt <= cnt - 1'b1;
    end

    assign pulse[g]   = busy & clear_n[g];
    assign pulse_n[g] = ~pulse[g];
  end

endmodule

// File: rtl/oneshot_pair_chk.sv
module oneshot_pair_chk #(
  parameter int NCH      = 2,
  parameter int PERIOD_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NCH-1:0]          clear_n,
  input logic [NCH*PERIOD_W-1:0] period,
  input logic [NCH-1:0]          pulse,
  input logic [NCH-1:0]          pulse_n
);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    AST_CLEAR_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_n[g] |-> (!pulse[g] && pulse_n[g])); // R2

    AST_OUT_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_n[g] == ~pulse[g]); // R11

    AST_ZERO_PERIOD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(period[g*PERIOD_W +: PERIOD_W]) == '0 && !$past(pulse[g])) |-> !pulse[g]); // R8

    AST_RELEASE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse[g]) |-> $past(clear_n[g])); // R9
  end

endmodule

bind oneshot_pair oneshot_pair_chk #(.NCH(NCH), .PERIOD_W(PERIOD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear_n(clear_n), .period(period),
  .pulse(pulse), .pulse_n(pulse_n));

// File: tb/oneshot_pair_bench.sv
module oneshot_pair_bench;
  localparam int NCH = 2;
  localparam int PW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0]    lead_trig = '0;
  logic [NCH-1:0]    trail_trig = '1;
  logic [NCH-1:0]    clear_n = '1;
  logic [NCH-1:0]    retrig_en = '1;
  logic [NCH*PW-1:0] period = {8'd5, 8'd5};
  logic [NCH-1:0]    pulse, pulse_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  oneshot_pair #(.NCH(NCH), .PERIOD_W(PW)) u_oneshot_pair (
    .clk(clk), .rst_n(rst_n), .lead_trig(lead_trig), .trail_trig(trail_trig),
    .clear_n(clear_n), .retrig_en(retrig_en), .period(period),
    .pulse(pulse), .pulse_n(pulse_n));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_trig(input int ch, input bit use_trail, input bit active);
    if (use_trail) trail_trig[ch] = ~active;
    else           lead_trig[ch]  = active;
  endtask

  task automatic run_shot(input int ch, input bit use_trail, input int p, input int d,
                          input bit rmode, input int exp_w, input string tag);
    int first, width;
    bit comp_ok;
    period[ch*PW +: PW] = p[PW-1:0];
    retrig_en[ch] = rmode;
    @(negedge clk);
    set_trig(ch, use_trail, 1'b1);
    first = -1; width = 0; comp_ok = 1'b1;
    for (int k = 1; k <= p + d + 12; k++) begin
      @(negedge clk);
      if (pulse[ch]) begin
        if (first < 0) first = k;
        width++;
      end
      if (pulse_n[ch] !== ~pulse[ch]) comp_ok = 1'b0;
      if (k == 1) set_trig(ch, use_trail, 1'b0);
      if (d > 0 && k == d) set_trig(ch, use_trail, 1'b1);
      if (d > 0 && k == d + 1) set_trig(ch, use_trail, 1'b0);
    end
    chk(width == exp_w, {tag, " width"}, width, exp_w);
    if (exp_w > 0) chk(first == 3, {tag, " latency"}, first, 3);
    chk(comp_ok, "R11 complement", comp_ok, 1);
  endtask

  task automatic idle_check(input int ch, input int n, input string tag);
    int highs;
    highs = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pulse[ch]) highs++;
    end
    chk(highs == 0, tag, highs, 0);
  endtask

  initial begin
    #200000;
    chk(1'b0, "watchdog", 0, 1);
    done = 1'b1;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pulse == '0, "R1 pulse after reset", pulse, 0);
    chk(pulse_n == '1, "R1 pulse_n after reset", pulse_n, 3);
    idle_check(0, 8, "R1 idle ch0");
    idle_check(1, 1, "R1 idle ch1");

    // single-trigger sweep: both edges, both channels
    for (int ch = 0; ch < NCH; ch++)
      for (int t = 0; t < 2; t++)
        for (int p = 1; p <= 6; p++)
          run_shot(ch, bit'(t), p, 0, 1'b1, p, t ? "R4 trail start" : "R3 lead start");

    // paired triggers: extending and fixed modes
    for (int ch = 0; ch < NCH; ch++)
      for (int p = 2; p <= 6; p++)
        for (int d = 2; d <= p; d++) begin
          run_shot(ch, 1'b0, p, d, 1'b1, d + p, "R6 retrigger extend");
          run_shot(ch, 1'b1, p, d, 1'b0, p, "R7 fixed ignores");
        end

    // zero period
    run_shot(0, 1'b0, 0, 0, 1'b1, 0, "R8 zero period");
    run_shot(1, 1'b1, 0, 3, 1'b1, 0, "R8 zero period trail");

    // gating and static levels (move to blocked levels under clear)
    period[0 +: PW] = 8'd5;
    retrig_en[0] = 1'b1;
    @(negedge clk); clear_n[0] = 1'b0;
    @(negedge clk); lead_trig[0] = 1'b1;
    repeat (3) @(negedge clk); trail_trig[0] = 1'b0;
    repeat (4) @(negedge clk); clear_n[0] = 1'b1;
    idle_check(0, 10, "R5 static levels");
    lead_trig[0] = 1'b0;
    idle_check(0, 4, "R5 lead fall");
    lead_trig[0] = 1'b1;
    idle_check(0, 10, "R5 lead rise blocked");
    trail_trig[0] = 1'b1;
    idle_check(0, 4, "R5 trail rise");
    trail_trig[0] = 1'b0;
    idle_check(0, 10, "R5 trail fall blocked");
    clear_n[0] = 1'b0;
    @(negedge clk); lead_trig[0] = 1'b0; trail_trig[0] = 1'b1;
    repeat (4) @(negedge clk); clear_n[0] = 1'b1;
    idle_check(0, 6, "R9 release no start");

    // clear lined up with detection cycle
    @(negedge clk); lead_trig[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); clear_n[0] = 1'b0;
    @(negedge clk); clear_n[0] = 1'b1; lead_trig[0] = 1'b0;
    idle_check(0, 10, "R9 same-cycle trigger discarded");

    // clear in mid pulse
    period[0 +: PW] = 8'd8;
    @(negedge clk); lead_trig[0] = 1'b1;
    repeat (5) @(negedge clk);
    chk(pulse[0] == 1'b1, "R3 pulse active before clear", pulse[0], 1);
    clear_n[0] = 1'b0; lead_trig[0] = 1'b0;
    @(negedge clk);
    chk(pulse[0] == 1'b0 && pulse_n[0] == 1'b1, "R2 clear forces low", pulse[0], 0);
    lead_trig[0] = 1'b1;
    repeat (2) @(negedge clk); lead_trig[0] = 1'b0;
    repeat (2) @(negedge clk); trail_trig[0] = 1'b0;
    repeat (2) @(negedge clk); trail_trig[0] = 1'b1;
    idle_check(0, 4, "R2 clear held with triggers");
    clear_n[0] = 1'b1;
    idle_check(0, 12, "R9 no resume after clear");

    // independence: different periods together, then clear on the other
    period = {8'd7, 8'd3};
    retrig_en = '1;
    begin
      int w0, w1;
      w0 = 0; w1 = 0;
      @(negedge clk); lead_trig = '1;
      for (int k = 1; k <= 15; k++) begin
        @(negedge clk);
        if (pulse[0]) w0++;
        if (pulse[1]) w1++;
        if (k == 1) lead_trig = '0;
      end
      chk(w0 == 3, "R10 ch0 width", w0, 3);
      chk(w1 == 7, "R10 ch1 width", w1, 7);
    end
    clear_n[1] = 1'b0;
    run_shot(0, 1'b0, 4, 0, 1'b1, 4, "R10 ch0 with ch1 cleared");
    chk(pulse[1] == 1'b0, "R10 ch1 cleared", pulse[1], 0);
    clear_n[1] = 1'b1;
    idle_check(1, 6, "R10 ch1 quiet");

    done = 1'b1;
  end

  initial begin
    wait (done);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule